// File: doc/BRIEF.md
# Programmable Interval Timer with Dual-Priority Interrupts

This block is a down-counting interval timer with a 32-bit width. A register write port loads a count register, a period register and a small control register. The control register holds a run bit and two interrupt unmask bits. While the run bit is set, the count falls by one on every clock. When the count sits at zero, the next clock reloads it from the period register. On that same clock the block raises a one-clock expiry pulse and one-clock interrupt requests on a high-priority line and a low-priority line. A period value of P therefore gives one expiry every P+1 clocks.

Both interrupt lines are masked after reset. Each line fires only when its own unmask bit is set. The current count is brought out so that the surrounding logic can observe it. A write to the count register always wins over the decrement or reload in the same cycle. While the timer is stopped, this write is how a starting value is loaded before the run bit is set. Priority arbitration of the two requests belongs to the interrupt controller that receives them.

Top module: `interval_timer`

## Requirements
- R1: Reset clears the count, the period, the run bit and both unmask bits, so countOut reads 0 and expiryPulse, irqHigh and irqLow are low. After reset is released, the count stays at 0 and nothing fires until the run bit is set.
- R2: While the run bit is clear, the count holds its value and a zero count raises no expiry. A write with wrSel = 0 loads wrData into the count, and countOut shows the new value after the next clock.
- R3: While the run bit (control bit 0, written with wrSel = 2) is set and the count is non-zero, countOut falls by exactly one on each clock.
- R4: While the run bit is set and the count is zero, the next clock loads the period register into the count and sets expiryPulse high for that one clock.
- R5: With a constant period P, expiryPulse is high once every P+1 clocks. A period of 0 makes it high on every clock.
- R6: irqHigh pulses together with expiryPulse only when control bit 1 was set at the clock that produced the expiry.
- R7: irqLow pulses together with expiryPulse only when control bit 2 was set at the clock that produced the expiry.
- R8: A count write made while the run bit is set replaces the decrement or reload in that cycle. A count write made while the count is zero therefore raises no expiry.
- R9: A period write (wrSel = 1) takes effect at the next reload, without disturbing the count in progress. A write with wrSel = 3 changes no state.
- R10: Clearing the run bit freezes the count. The clock that registers the clear still applies one final decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 count, 1 period, 2 control, 3 unused |
| wrData | input | 32 | Write data; control uses bit 0 run, bit 1 high unmask, bit 2 low unmask |
| countOut | output | 32 | Current count value |
| expiryPulse | output | 1 | One-clock pulse on each expiry |
| irqHigh | output | 1 | High-priority interrupt request pulse |
| irqLow | output | 1 | Low-priority interrupt request pulse |

## Verification
A wrong count value shows on countOut one clock after the edge that produced it. It also moves every later expiry, so a single off-by-one error shifts each following expiryPulse by a whole clock. A wrong run or unmask bit shows as an expiry or interrupt pulse that is missing or extra at the exact clock where the zero count meets the reload. The stimulus therefore checks countOut and all three pulses after every edge, across two periods, a mid-run period change, a count write at zero, and a period of zero.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_SPARE  = 2'd3
  } regSel_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_HI_BIT  = 1;
  localparam int CTRL_LO_BIT  = 2;
  localparam int CTRL_W       = 3;

  typedef struct packed {
    logic loadCount;
    logic loadPeriod;
    logic decrement;
    logic reload;
  } dpStrobes_t;

endpackage

// File: rtl/interval_timer_ctrl.sv
module interval_timer_ctrl
  import interval_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [CTRL_W-1:0] wrCtrl,
  input  logic              countIsZero,
  output dpStrobes_t        strobes,
  output logic              expiryPulse,
  output logic              irqHigh,
  output logic              irqLow
);

  logic runEn;
  logic unmaskHigh;
  logic unmaskLow;
  logic countWrite;

  assign countWrite = wrEn && (wrSel == SEL_COUNT);

  always_comb begin
    strobes            = '0;
    strobes.loadCount  = countWrite;
    strobes.loadPeriod = wrEn && (wrSel == SEL_PERIOD);
    strobes.decrement  = runEn && !countIsZero && !countWrite;
    strobes.reload     = runEn && countIsZero && !countWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn      <= 1'b0;
      unmaskHigh <= 1'b0;
      unmaskLow  <= 1'b0;
    end else if (wrEn && (wrSel == SEL_CTRL)) begin
      runEn      <= wrCtrl[CTRL_RUN_BIT];
      unmaskHigh <= wrCtrl[CTRL_HI_BIT];
      unmaskLow  <= wrCtrl[CTRL_LO_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expiryPulse <= 1'b0;
      irqHigh     <= 1'b0;
      irqLow      <= 1'b0;
    end else begin
      expiryPulse <= strobes.reload;
      irqHigh     <= strobes.reload && unmaskHigh;
      irqLow      <= strobes.reload && unmaskLow;
    end
  end

  // R4: an expiry only follows a running, zero, unwritten count
  assert_expiry_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(expiryPulse) |-> $past(runEn && countIsZero && !countWrite));

  // R6: high request never appears without an expiry or with the line masked
  assert_irq_high_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqHigh |-> (expiryPulse && $past(unmaskHigh)));

  // R7: low request never appears without an expiry or with the line masked
  assert_irq_low_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqLow |-> (expiryPulse && $past(unmaskLow)));

  // R1: stopped timer raises nothing on the following clock
  assert_stopped_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn) |=> !expiryPulse);

endmodule

// File: rtl/interval_timer_dp.sv
module interval_timer_dp
  import interval_timer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] countQ,
  output logic             countIsZero
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] periodQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobes.loadCount) begin
      countQ <= wrData;
    end else if (strobes.reload) begin
      countQ <= periodQ;
    end else if (strobes.decrement) begin
      countQ <= countQ - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodQ <= '0;
    end else if (strobes.loadPeriod) begin
      periodQ <= wrData;
    end
  end

  assign countIsZero = (countQ == '0);

  // R3: a decrement strobe lowers the count by exactly one
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.decrement |=> (countQ == $past(countQ) - ONE));

  // R4: a reload strobe copies the period held at that clock
  assert_reload_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reload |=> (countQ == $past(periodQ)));

  // R8: a count write lands unchanged, whatever else was due
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCount |=> (countQ == $past(wrData)));

  // R2: with no strobe the count holds
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadCount || strobes.reload || strobes.decrement) |=> $stable(countQ));

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import interval_timer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] countOut,
  output logic             expiryPulse,
  output logic             irqHigh,
  output logic             irqLow
);

  dpStrobes_t strobes;
  logic       countIsZero;

  interval_timer_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrSel       (wrSel),
    .wrCtrl      (wrData[CTRL_W-1:0]),
    .countIsZero (countIsZero),
    .strobes     (strobes),
    .expiryPulse (expiryPulse),
    .irqHigh     (irqHigh),
    .irqLow      (irqLow)
  );

  interval_timer_dp #(.WIDTH(WIDTH)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (wrData),
    .countQ      (countOut),
    .countIsZero (countIsZero)
  );

endmodule

// File: tb/interval_timer_tb_top.sv
`timescale 1ns/1ps
module interval_timer_tb_top;

  typedef struct packed {
    logic        we;
    logic [1:0]  sel;
    logic [31:0] data;
    logic [31:0] expCount;
    logic        expExp;
    logic        expHi;
    logic        expLo;
    logic [31:0] tag;
  } vec_t;

  localparam int NV = 41;
  // Each entry: write?, select, data, then expected outputs after the edge.
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd1, 32'd5, 32'd0, 1'b0, 1'b0, 1'b0, "R2"},  // period 5, stopped zero count: no expiry
    '{1'b1, 2'd0, 32'd3, 32'd3, 1'b0, 1'b0, 1'b0, "R2"},  // load count while stopped
    '{1'b1, 2'd2, 32'd3, 32'd3, 1'b0, 1'b0, 1'b0, "R3"},  // run + high unmask
    '{1'b0, 2'd0, 32'd0, 32'd2, 1'b0, 1'b0, 1'b0, "R3"},
    '{1'b0, 2'd0, 32'd0, 32'd1, 1'b0, 1'b0, 1'b0, "R3"},
    '{1'b0, 2'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, "R3"},
    '{1'b0, 2'd0, 32'd0, 32'd5, 1'b1, 1'b1, 1'b0, "R4"},  // reload + pulse, high only
    '{1'b0, 2'd0, 32'd0, 32'd4, 1'b0, 1'b0, 1'b0, "R4"},  // pulse lasts one clock
    '{1'b0, 2'd0, 32'd0, 32'd3, 1'b0, 1'b0, 1'b0, "R5"},
    '{1'b0, 2'd0, 32'd0, 32'd2, 1'b0, 1'b0, 1'b0, "R5"},
    '{1'b0, 2'd0, 32'd0, 32'd1, 1'b0, 1'b0, 1'b0, "R5"},
    '{1'b0, 2'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, "R5"},
    '{1'b0, 2'd0, 32'd0, 32'd5, 1'b1, 1'b1, 1'b0, "R5"},  // six clocks after previous expiry
    '{1'b1, 2'd2, 32'd5, 32'd4, 1'b0, 1'b0, 1'b0, "R7"},  // run + low unmask only
    '{1'b1, 2'd1, 32'd2, 32'd3, 1'b0, 1'b0, 1'b0, "R9"},  // period change mid-run
    '{1'b0, 2'd0, 32'd0, 32'd2, 1'b0, 1'b0, 1'b0, "R9"},
    '{1'b0, 2'd0, 32'd0, 32'd1, 1'b0, 1'b0, 1'b0, "R9"},
    '{1'b0, 2'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, "R9"},
    '{1'b0, 2'd0, 32'd0, 32'd2, 1'b1, 1'b0, 1'b1, "R7"},  // new period used, low line fires
    '{1'b0, 2'd0, 32'd0, 32'd1, 1'b0, 1'b0, 1'b0, "R5"},
    '{1'b0, 2'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, "R5"},
    '{1'b0, 2'd0, 32'd0, 32'd2, 1'b1, 1'b0, 1'b1, "R5"},  // interval of three
    '{1'b1, 2'd0, 32'd7, 32'd7, 1'b0, 1'b0, 1'b0, "R8"},  // write beats decrement
    '{1'b0, 2'd0, 32'd0, 32'd6, 1'b0, 1'b0, 1'b0, "R3"},
    '{1'b1, 2'd0, 32'd1, 32'd1, 1'b0, 1'b0, 1'b0, "R8"},
    '{1'b0, 2'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, "R3"},
    '{1'b1, 2'd0, 32'd4, 32'd4, 1'b0, 1'b0, 1'b0, "R8"},  // write at zero suppresses expiry
    '{1'b1, 2'd3, 32'd0, 32'd3, 1'b0, 1'b0, 1'b0, "R9"},  // spare select ignored
    '{1'b1, 2'd2, 32'd0, 32'd2, 1'b0, 1'b0, 1'b0, "R10"}, // stop: last decrement applies
    '{1'b0, 2'd0, 32'd0, 32'd2, 1'b0, 1'b0, 1'b0, "R10"}, // frozen
    '{1'b0, 2'd0, 32'd0, 32'd2, 1'b0, 1'b0, 1'b0, "R10"},
    '{1'b1, 2'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, "R2"},
    '{1'b0, 2'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, "R2"},  // stopped zero: no expiry
    '{1'b1, 2'd2, 32'd7, 32'd0, 1'b0, 1'b0, 1'b0, "R6"},  // run + both unmasked
    '{1'b0, 2'd0, 32'd0, 32'd2, 1'b1, 1'b1, 1'b1, "R6"},
    '{1'b0, 2'd0, 32'd0, 32'd1, 1'b0, 1'b0, 1'b0, "R3"},
    '{1'b1, 2'd1, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, "R9"},  // period 0
    '{1'b0, 2'd0, 32'd0, 32'd0, 1'b1, 1'b1, 1'b1, "R5"},
    '{1'b0, 2'd0, 32'd0, 32'd0, 1'b1, 1'b1, 1'b1, "R5"},  // expiry every clock
    '{1'b1, 2'd2, 32'd0, 32'd0, 1'b1, 1'b1, 1'b1, "R6"},  // old masks still apply at this clock
    '{1'b0, 2'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, "R10"}  // stopped and masked
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [31:0] wrData = 32'd0;
  logic [31:0] countOut;
  logic        expiryPulse;
  logic        irqHigh;
  logic        irqLow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  interval_timer dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrSel       (wrSel),
    .wrData      (wrData),
    .countOut    (countOut),
    .expiryPulse (expiryPulse),
    .irqHigh     (irqHigh),
    .irqLow      (irqLow)
  );

  task automatic checkOut(input logic [31:0] eCount, input logic eExp,
                          input logic eHi, input logic eLo,
                          input logic [31:0] tag, input int idx);
    checks++;
    if (countOut !== eCount || expiryPulse !== eExp || irqHigh !== eHi || irqLow !== eLo) begin
      fails++;
      $display("FAIL %s step %0d: got count=%0d exp=%b hi=%b lo=%b, expected count=%0d exp=%b hi=%b lo=%b",
               tag, idx, countOut, expiryPulse, irqHigh, irqLow, eCount, eExp, eHi, eLo);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] sel, input logic [31:0] data);
    wrEn = we;
    wrSel = sel;
    wrData = data;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut(32'd0, 1'b0, 1'b0, 1'b0, "R1", -1);  // values held in reset
    rstN = 1'b1;
    step(1'b0, 2'd0, 32'd0);
    step(1'b0, 2'd0, 32'd0);
    checkOut(32'd0, 1'b0, 1'b0, 1'b0, "R1", -2);  // idle after reset: stopped, masked

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].we, VECS[i].sel, VECS[i].data);
      checkOut(VECS[i].expCount, VECS[i].expExp, VECS[i].expHi, VECS[i].expLo, VECS[i].tag, i);
    end

    // R1: reset during a running count clears everything
    step(1'b1, 2'd0, 32'd9);
    step(1'b1, 2'd1, 32'd4);
    step(1'b1, 2'd2, 32'd7);
    step(1'b0, 2'd0, 32'd0);
    checkOut(32'd8, 1'b0, 1'b0, 1'b0, "R3", -3);
    rstN = 1'b0;
    step(1'b0, 2'd0, 32'd0);
    checkOut(32'd0, 1'b0, 1'b0, 1'b0, "R1", -4);
    rstN = 1'b1;
    repeat (3) step(1'b0, 2'd0, 32'd0);
    checkOut(32'd0, 1'b0, 1'b0, 1'b0, "R1", -5);  // run bit cleared by reset: no expiry

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule